// File: doc/BRIEF.md
# Selectable Output Clock Divider

This block is the digital output stage of an Ethernet reference clock generator. It takes a fast source clock and divides it by one of three ratios chosen by a 2-bit code: 4, 5 or 10. From a 625 MHz source these ratios give 156.25 MHz, 125 MHz and 62.5 MHz. Every ratio, including the odd one, has a 50% duty cycle. The divided clock drives a set of identical output pairs. Each pair has a true signal and a complement signal.

A bypass input picks where the divider's clock comes from. When bypass is low, the clock comes from the PLL. When bypass is high, it comes from a test clock. An active-high master reset forces every true output low and every complement output high at once. It also holds the divider cleared.

The release of master reset is retimed to the selected source clock, so the first high phase after release has full width. The ratio code is taken only while the divider is held in reset. A new ratio therefore never cuts a phase short. The bypass input is also changed only under reset.

Top module: `refclk_out_divider`

## Requirements
- R1: Ratio code 2'b00 gives an output period of 4 source cycles, high for 2 cycles.
- R2: Ratio code 2'b01 gives an output period of 5 source cycles, high for exactly 2.5 cycles. The output rises on a rising source edge and falls on a falling source edge.
- R3: Ratio code 2'b10 gives an output period of 10 source cycles, high for 5 cycles.
- R4: Ratio code 2'b11 is reserved. While it is in force and master reset is low, every true output stays low and every complement stays high.
- R5: While master reset is high, every true output is low and every complement is high. This holds from the same instant, with no clock edge needed.
- R6: After master reset falls, the outputs rise at the third rising source edge at which master reset is sampled low. The first high phase has full width.
- R7: The ratio code is captured only while the divider is held in reset. A change of code while running has no effect until the next reset.
- R8: When bypass is low, the divider runs from the PLL clock. When bypass is high, it runs from the test clock. Bypass is changed only while master reset is high.
- R9: All output pairs carry the same waveform, and each complement is always the inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pll_clk_i | input | 1 | Source clock from the PLL |
| test_clk_i | input | 1 | Alternative test clock |
| bypass_i | input | 1 | 0 selects pll_clk_i, 1 selects test_clk_i |
| ratio_sel_i | input | 2 | Ratio code: 00 → /4, 01 → /5, 10 → /10, 11 reserved |
| mreset_i | input | 1 | Master reset, active high |
| clk_p_o | output | NUM_OUT | True outputs of the pairs |
| clk_n_o | output | NUM_OUT | Complement outputs of the pairs |

## Verification
Master reset reaches the outputs through gating only, so its effect shows within the same source half-cycle. The bench also checks it 1 ns after driving it. The divider sees a release two rising source edges after master reset is sampled low, and the output rises on the third such edge. From that edge on, the expected level is a function of the number of half-periods elapsed, taken modulo twice the ratio. The reference model counts rising edges of the selected source. It evaluates that function 1 ns after every rising and falling edge. Inputs change 2 ns after a rising edge, so no sample coincides with a change.

// File: rtl/oclk_pkg.sv
`timescale 1ns/1ps
// Shared types for the selectable output clock divider.
// Assumes the ratio code is two bits wide, with one reserved value.
package oclk_pkg;
    typedef enum logic [1:0] {
        RATIO_A   = 2'b00,
        RATIO_B   = 2'b01,
        RATIO_C   = 2'b10,
        RATIO_RSV = 2'b11
    } ratio_code_e;

    localparam int SYNC_DEPTH_DEFAULT = 2;
endpackage

// File: rtl/src_clk_mux.sv
`timescale 1ns/1ps
// Source clock selector.
// Picks the PLL clock or the test clock as the divider's clock.
// Assumes the select changes only while the divider is held in reset,
// so a glitch at the switch point reaches only cleared state.
module src_clk_mux (
    input  logic pll_clk_i,
    input  logic test_clk_i,
    input  logic bypass_i,
    output logic src_clk_o
);
    // Route the chosen clock to the divider.
    always_comb begin
        if (bypass_i) begin
            src_clk_o = test_clk_i;
        end else begin
            src_clk_o = pll_clk_i;
        end
    end
endmodule

// File: rtl/release_sync.sv
`timescale 1ns/1ps
// Master reset release retimer.
// Turns the active-high master reset into an active-low reset that is
// synchronous to the source clock. Release takes STAGES rising edges.
// Assumes STAGES >= 2 and a master reset pulse of at least STAGES cycles.
module release_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic mreset_i,
    output logic rst_n_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the inverted master reset through the retiming chain.
    always_ff @(posedge clk_i) begin
        chain_q <= {chain_q[STAGES-2:0], ~mreset_i};
    end

    assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/ratio_divider.sv
`timescale 1ns/1ps
// Dual-edge ratio divider.
// A rising-edge counter makes a phase that is high for floor(N/2) cycles.
// For odd N, a copy retimed on the falling edge is ORed in, which stretches
// the high phase by half a cycle to give exactly N/2 cycles high.
// The ratio code is captured only while rst_n_i is low.
// The reserved code keeps the divider cleared.
// Assumes rst_n_i is synchronous to clk_i.
module ratio_divider
    import oclk_pkg::*;
#(
    parameter int DIV0 = 4,
    parameter int DIV1 = 5,
    parameter int DIV2 = 10
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic [1:0] ratio_sel_i,
    output logic       div_o
);
    localparam int MAX01   = (DIV0 > DIV1) ? DIV0 : DIV1;
    localparam int MAX_DIV = (MAX01 > DIV2) ? MAX01 : DIV2;
    localparam int CNT_W   = $clog2(MAX_DIV);

    ratio_code_e        ratio_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cnt_nxt;
    logic [CNT_W-1:0]   last_val;
    logic [CNT_W-1:0]   high_len;
    logic               odd_mode;
    logic               hold;
    logic               pos_q;
    logic               neg_q;

    // Capture the ratio code while the divider is in reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            ratio_q <= ratio_code_e'(ratio_sel_i);
        end
    end

    // Decode the captured code into terminal count, high length and parity.
    always_comb begin
        case (ratio_q)
            RATIO_A: begin
                last_val = CNT_W'(DIV0 - 1);
                high_len = CNT_W'(DIV0 / 2);
                odd_mode = (DIV0 % 2) != 0;
            end
            RATIO_B: begin
                last_val = CNT_W'(DIV1 - 1);
                high_len = CNT_W'(DIV1 / 2);
                odd_mode = (DIV1 % 2) != 0;
            end
            RATIO_C: begin
                last_val = CNT_W'(DIV2 - 1);
                high_len = CNT_W'(DIV2 / 2);
                odd_mode = (DIV2 % 2) != 0;
            end
            default: begin
                last_val = '0;
                high_len = '0;
                odd_mode = 1'b0;
            end
        endcase
    end

    // Hold the divider cleared in reset or on the reserved code.
    assign hold = !rst_n_i || (ratio_q == RATIO_RSV);

    // Next count wraps to zero at the terminal value and from the cleared state.
    assign cnt_nxt = (cnt_q >= last_val) ? '0 : cnt_q + 1'b1;

    // Rising-edge counter and phase register.
    always_ff @(posedge clk_i) begin
        if (hold) begin
            cnt_q <= '1;
            pos_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            pos_q <= (cnt_nxt < high_len);
        end
    end

    // Falling-edge copy of the phase for the extra half cycle at odd ratios.
    always_ff @(negedge clk_i) begin
        if (hold) begin
            neg_q <= 1'b0;
        end else begin
            neg_q <= pos_q;
        end
    end

    assign div_o = pos_q | (odd_mode & neg_q);

    // R7
    ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $past(rst_n_i) |-> $stable(ratio_q));

    // R1
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ratio_q != RATIO_RSV && cnt_q != '1) |-> (cnt_q <= last_val));

    // R6
    first_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!$past(rst_n_i) && ratio_q != RATIO_RSV) |=> (pos_q && cnt_q == '0));

    // R4
    rsv_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ratio_q == RATIO_RSV) |-> !pos_q);

    // R2
    phase_start_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(pos_q) |-> (cnt_q == '0));
endmodule

// File: rtl/out_pair.sv
`timescale 1ns/1ps
// One output pair: a true signal and its complement from a shared clock.
// Assumes the gated clock is already forced low during master reset.
module out_pair (
    input  logic clk_i,
    output logic p_o,
    output logic n_o
);
    // Drive the true and complement sides of the pair.
    always_comb begin
        p_o = clk_i;
        n_o = ~clk_i;
    end
endmodule

// File: rtl/refclk_out_divider.sv
`timescale 1ns/1ps
// Selectable output clock divider, top level.
// Selects the source clock, retimes the master reset release, divides by
// the captured ratio and fans the result out to NUM_OUT identical pairs.
// Master reset also gates the outputs directly, so it forces them at once.
// Assumes bypass_i changes only while mreset_i is high.
module refclk_out_divider
    import oclk_pkg::*;
#(
    parameter int NUM_OUT     = 4,
    parameter int DIV_SEL0    = 4,
    parameter int DIV_SEL1    = 5,
    parameter int DIV_SEL2    = 10,
    parameter int SYNC_STAGES = SYNC_DEPTH_DEFAULT
) (
    input  logic               pll_clk_i,
    input  logic               test_clk_i,
    input  logic               bypass_i,
    input  logic [1:0]         ratio_sel_i,
    input  logic               mreset_i,
    output logic [NUM_OUT-1:0] clk_p_o,
    output logic [NUM_OUT-1:0] clk_n_o
);
    logic src_clk;
    logic rst_n;
    logic div_clk;
    logic live_clk;

    src_clk_mux u_mux (
        .pll_clk_i  (pll_clk_i),
        .test_clk_i (test_clk_i),
        .bypass_i   (bypass_i),
        .src_clk_o  (src_clk)
    );

    release_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i    (src_clk),
        .mreset_i (mreset_i),
        .rst_n_o  (rst_n)
    );

    ratio_divider #(.DIV0(DIV_SEL0), .DIV1(DIV_SEL1), .DIV2(DIV_SEL2)) u_div (
        .clk_i       (src_clk),
        .rst_n_i     (rst_n),
        .ratio_sel_i (ratio_sel_i),
        .div_o       (div_clk)
    );

    // Force the divided clock low at once while master reset is high.
    assign live_clk = div_clk & ~mreset_i;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_pair
        out_pair u_pair (
            .clk_i (live_clk),
            .p_o   (clk_p_o[g]),
            .n_o   (clk_n_o[g])
        );
    end
endmodule

// File: tb/test_refclk_out_divider.sv
`timescale 1ns/1ps
// Bench: a behavioural reference counts source edges since release and
// compares every pair 1 ns after each rising and falling source edge.
module test_refclk_out_divider;
    logic       pclk = 1'b0;
    logic       tclk = 1'b0;
    logic       bypass = 1'b0;
    logic       mreset = 1'b1;
    logic [1:0] sel = 2'b00;
    logic [3:0] q;
    logic [3:0] qn;
    logic       mclk;

    int         checks = 0;
    int         fails = 0;
    string      cur_req = "R5";
    int         rel = 0;
    logic [1:0] cap = 2'b00;
    logic       up;
    logic       e;
    int         h;
    int         n;

    always #4 pclk = ~pclk;
    always #10 tclk = ~tclk;
    assign mclk = bypass ? tclk : pclk;

    refclk_out_divider i_refclk_out_divider (
        .pll_clk_i   (pclk),
        .test_clk_i  (tclk),
        .bypass_i    (bypass),
        .ratio_sel_i (sel),
        .mreset_i    (mreset),
        .clk_p_o     (q),
        .clk_n_o     (qn)
    );

    function automatic int ratio_of(logic [1:0] c);
        case (c)
            2'b00:   return 4;
            2'b01:   return 5;
            default: return 10;
        endcase
    endfunction

    task automatic note(string req, string what, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at %0t: actual=%b expected=%b", req, what, $time, act, exp);
        end
    endtask

    // Reference model: level due after each edge of the selected source.
    always @(posedge mclk or negedge mclk) begin
        up = mclk;
        if (up) begin
            if (mreset) rel = 0;
            else        rel = rel + 1;
            if (rel <= 2) cap = sel;
        end
        #1;
        if (mreset || cap == 2'b11 || rel < 3) begin
            e = 1'b0;
        end else begin
            n = ratio_of(cap);
            h = 2 * (rel - 3) + (up ? 0 : 1);
            e = (h % (2 * n)) < n;
        end
        note(cur_req, "true outputs", q, {4{e}});
        note("R9", "complement outputs", qn, ~q);
    end

    task automatic cyc(int k);
        repeat (k) @(posedge mclk);
        #2;
    endtask

    // R5 immediate force, then new source and code under reset, then release.
    task automatic restart(logic byp, logic [1:0] s);
        cur_req = "R5";
        mreset = 1'b1;
        #1;
        note("R5", "immediate true low", q, 4'b0000);
        note("R5", "immediate complement high", qn, 4'b1111);
        cyc(4);
        bypass = byp;
        sel = s;
        cyc(4);
        mreset = 1'b0;
        cur_req = "R6";
        cyc(8);
    endtask

    initial begin
        cyc(6);
        note("R5", "reset true low", q, 4'b0000);
        note("R5", "reset complement high", qn, 4'b1111);
        mreset = 1'b0;
        cur_req = "R6";
        cyc(8);
        cur_req = "R1";
        cyc(60);
        cur_req = "R7";
        sel = 2'b10;
        cyc(40);
        restart(1'b0, 2'b01);
        cur_req = "R2";
        cyc(60);
        restart(1'b0, 2'b10);
        cur_req = "R3";
        cyc(60);
        restart(1'b0, 2'b11);
        cur_req = "R4";
        cyc(40);
        restart(1'b1, 2'b00);
        cur_req = "R8";
        cyc(60);
        restart(1'b1, 2'b01);
        cur_req = "R8";
        cyc(40);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule